// File: doc/BRIEF.md
# Burst Bus Initiator

This block is the initiating side of a synchronous, multiplexed address/data bus that carries bursts of any length. A local client asks for a burst by pulsing a start strobe. With that strobe it gives a direction, a command code, a word start address and a beat count. The initiator then runs the whole bus sequence. First comes an address phase with the bus-hold line raised. On reads, a turnaround cycle follows while the shared lines change driver. Then come the data phases. A word moves only on a rising edge where the initiator-ready and target-ready lines are both high. The bus-hold line drops while the last word is in flight. Once that word has moved, the bus is released.

On writes, the local side offers words through a show-ahead source, using a valid flag and a pop strobe. On reads, words are handed back through a push strobe. A full flag from the read side, or an empty write source, makes the initiator insert wait states. A word address output follows the data phase in progress.

Top module: `bbi_initiator`

## Requirements
- R1: While reset is high and right after it, busy, bus_hold, init_rdy, ad_oe, rd_push and wr_pop are all low.
- R2: In the cycle after a start is accepted, the address phase is on the bus. In that cycle bus_hold=1, ad_oe=1, init_rdy=0, ad_out holds the start address zero-extended, cbe_out holds the command and busy=1.
- R3: A word moves only on a rising edge with init_rdy=1 and tgt_rdy=1. A burst moves exactly start_len words. Write words appear on ad_out, with ad_oe=1, in the order the source supplied them.
- R4: At each edge that moves a word, bus_hold is high if and only if more than one word remains, this one included. Once bus_hold falls with init_rdy high, it stays low until the burst ends.
- R5: Once init_rdy is high, it stays high until tgt_rdy is also high on an edge.
- R6: On a read, the cycle after the address phase has ad_oe=0, and no word moves in that cycle.
- R7: A word read at an edge is presented on rd_data with rd_push=1 during the next cycle, in bus order.
- R8: Suppose a data or address phase has init_rdy=0 and the block cannot supply or take a word: wr_valid=0 on a write, or rd_full=1 on a read. Then init_rdy is still 0 in the next cycle (a wait state). wr_pop is high only when wr_valid is high.
- R9: During data phase k of a burst (counting from 0), cur_addr equals the start address plus k, modulo 2^ADDR_W.
- R10: In the cycle after the final word moves, bus_hold, init_rdy and ad_oe are low and busy is low.
- R11: A start with start_len=0, or a start while busy, is ignored. Nothing reaches the bus and the running burst is unchanged.
- R12: In a one-word burst, bus_hold is high for the address phase only. The single word moves with bus_hold=0 and init_rdy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request strobe |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| start_cmd | input | CMD_W | Command code driven in the address phase |
| start_addr | input | ADDR_W | Word start address |
| start_len | input | LEN_W | Number of words, 0 is ignored |
| wr_data | input | DATA_W | Head word of the write source |
| wr_valid | input | 1 | Write source holds a word |
| wr_pop | output | 1 | Head word taken at this edge |
| rd_full | input | 1 | Read sink cannot take more words |
| rd_data | output | DATA_W | Word read from the bus |
| rd_push | output | 1 | rd_data is valid this cycle |
| busy | output | 1 | A burst is in progress |
| cur_addr | output | ADDR_W | Word address of the current data phase |
| bus_hold | output | 1 | Burst-in-progress line, drops for the last word |
| init_rdy | output | 1 | Initiator ready |
| tgt_rdy | input | 1 | Target ready |
| ad_out | output | DATA_W | Address/data drive value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | DATA_W | Address/data lines as seen on the bus |
| cbe_out | output | CMD_W | Command in the address phase, zero after it |

## Verification
The bench builds the block with DATA_W=32, ADDR_W=16, LEN_W=6 and CMD_W=4. With a 6-bit count, bursts of one word and of twenty words both fit, so one run covers the case where bus_hold drops at once and the long case. With a 16-bit address, a burst that starts at 0xFFFE can cross the wrap of the address counter. The target-ready line, the write source and the read-full flag can each stall the burst on its own pattern. This makes wait states land both before and during the final phase.

// File: rtl/bbi_pkg.sv
package bbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_TURN = 2'd2,
    ST_DATA = 2'd3
  } bbi_state_e;
endpackage

// File: rtl/bbi_beat_ctr.sv
// Remaining-word count and running word address of the current burst.
module bbi_beat_ctr #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              step,
  output logic [LEN_W-1:0]  rem,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      addr <= '0;
    end else if (load) begin
      rem  <= load_len;
      addr <= load_addr;
    end else if (step) begin
      rem  <= rem - LEN_ONE;
      addr <= addr + ADDR_ONE;
    end
  end
endmodule

// File: rtl/bbi_rd_capture.sv
// Registers a read word at the edge it moves and flags it for one cycle.
module bbi_rd_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grab,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_push
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_push <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_push <= grab;
      if (grab) rd_data <= ad_in;
    end
  end
endmodule

// File: rtl/bbi_ctrl.sv
// Phase sequencer: address phase, read turnaround, data phases, release.
module bbi_ctrl
  import bbi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 6,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic [CMD_W-1:0]  start_cmd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [LEN_W-1:0]  rem,
  input  logic              tgt_rdy,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_full,
  output bbi_state_e        st,
  output logic              is_wr,
  output logic              bus_hold,
  output logic              init_rdy,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [CMD_W-1:0]  cbe_out,
  output logic              wr_pop,
  output logic              load,
  output logic              step
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic             accept, done, finish, need_new, offer, hold_n;
  logic [LEN_W-1:0] rem_after;

  always_comb begin
    accept    = (st == ST_IDLE) && start && (start_len != '0);
    done      = (st == ST_DATA) && init_rdy && tgt_rdy;
    finish    = done && (rem == LEN_ONE);
    need_new  = (st == ST_ADDR) ||
                ((st == ST_DATA) && (!init_rdy || done) && !finish);
    offer     = is_wr ? wr_valid : !rd_full;
    rem_after = done ? (rem - LEN_ONE) : rem;
    // drop the hold line together with the last ready, never before it
    hold_n    = bus_hold && !((rem_after == LEN_ONE) && offer);
  end

  assign wr_pop = need_new && is_wr && wr_valid;
  assign load   = accept;
  assign step   = done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      is_wr    <= 1'b0;
      bus_hold <= 1'b0;
      init_rdy <= 1'b0;
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      cbe_out  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st       <= ST_ADDR;
            bus_hold <= 1'b1;
            ad_oe    <= 1'b1;
            ad_out   <= DATA_W'(start_addr);
            cbe_out  <= start_cmd;
            is_wr    <= start_wr;
          end
        end
        ST_ADDR: begin
          st       <= is_wr ? ST_DATA : ST_TURN;
          cbe_out  <= '0;
          init_rdy <= offer;
          bus_hold <= hold_n;
          ad_oe    <= is_wr;
          if (wr_pop) ad_out <= wr_data;
        end
        ST_TURN: st <= ST_DATA;
        ST_DATA: begin
          if (finish) begin
            st       <= ST_IDLE;
            bus_hold <= 1'b0;
            init_rdy <= 1'b0;
            ad_oe    <= 1'b0;
          end else if (need_new) begin
            init_rdy <= offer;
            bus_hold <= hold_n;
            if (wr_pop) ad_out <= wr_data;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bbi_initiator.sv
module bbi_initiator
  import bbi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 6,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic [CMD_W-1:0]  start_cmd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_pop,
  input  logic              rd_full,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_push,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              bus_hold,
  output logic              init_rdy,
  input  logic              tgt_rdy,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [CMD_W-1:0]  cbe_out
);
  bbi_state_e       st;
  logic             is_wr, load, step;
  logic [LEN_W-1:0] rem;

  bbi_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CMD_W(CMD_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_wr(start_wr), .start_cmd(start_cmd),
    .start_addr(start_addr), .start_len(start_len), .rem(rem), .tgt_rdy(tgt_rdy),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_full(rd_full), .st(st), .is_wr(is_wr),
    .bus_hold(bus_hold), .init_rdy(init_rdy), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_out(cbe_out), .wr_pop(wr_pop), .load(load), .step(step)
  );

  bbi_beat_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .load_addr(start_addr), .load_len(start_len),
    .step(step), .rem(rem), .addr(cur_addr)
  );

  bbi_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .grab(step && !is_wr), .ad_in(ad_in),
    .rd_data(rd_data), .rd_push(rd_push)
  );

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/bbi_checker.sv
module bbi_checker
  import bbi_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input bbi_state_e st,
  input logic       bus_hold,
  input logic       init_rdy,
  input logic       tgt_rdy,
  input logic       ad_oe,
  input logic       wr_pop,
  input logic       wr_valid
);
  a_r5_ready_held: assert property (@(posedge clk) disable iff (rst)
    init_rdy && !tgt_rdy |=> init_rdy);

  a_r4_hold_falls_with_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_hold) |-> init_rdy);

  a_r4_hold_stays_low: assert property (@(posedge clk) disable iff (rst)
    !bus_hold && init_rdy |=> !bus_hold);

  a_r10_release_after_last: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA) && init_rdy && tgt_rdy && !bus_hold |=> !init_rdy && !ad_oe && (st == ST_IDLE));

  a_r2_address_phase: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR) |-> bus_hold && ad_oe && !init_rdy);

  a_r6_turnaround_float: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TURN) |-> !ad_oe);

  a_r8_pop_needs_word: assert property (@(posedge clk) disable iff (rst)
    wr_pop |-> wr_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !bus_hold && !init_rdy && !ad_oe);
endmodule

bind bbi_initiator bbi_checker u_chk (
  .clk(clk), .rst(rst), .st(st), .bus_hold(bus_hold), .init_rdy(init_rdy),
  .tgt_rdy(tgt_rdy), .ad_oe(ad_oe), .wr_pop(wr_pop), .wr_valid(wr_valid)
);

// File: tb/bbi_initiator_tb.sv
`timescale 1ns/1ps
module bbi_initiator_tb;
  localparam int DATA_W = 32, ADDR_W = 16, LEN_W = 6, CMD_W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, start_wr = 1'b0;
  logic [CMD_W-1:0]  start_cmd = '0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [LEN_W-1:0]  start_len = '0;
  logic [DATA_W-1:0] wr_data = '0, ad_in = '0;
  logic wr_valid = 1'b0, rd_full = 1'b0, tgt_rdy = 1'b0;
  logic wr_pop, rd_push, busy, bus_hold, init_rdy, ad_oe;
  logic [DATA_W-1:0] rd_data, ad_out;
  logic [ADDR_W-1:0] cur_addr;
  logic [CMD_W-1:0]  cbe_out;

  bbi_initiator #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CMD_W(CMD_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_wr(start_wr), .start_cmd(start_cmd),
    .start_addr(start_addr), .start_len(start_len), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_pop(wr_pop), .rd_full(rd_full), .rd_data(rd_data), .rd_push(rd_push), .busy(busy),
    .cur_addr(cur_addr), .bus_hold(bus_hold), .init_rdy(init_rdy), .tgt_rdy(tgt_rdy),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .cbe_out(cbe_out)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc_n = 0, wd = 0;
  bit stress = 1'b0;
  logic [DATA_W-1:0] src_wr[$], exp_wr[$], exp_rd[$];
  logic [DATA_W-1:0] rd_seq = '0, wseq = '0;
  // bench view of the burst in progress
  bit in_burst = 0, pend_addr = 0, turn = 0, post_chk = 0, r8_arm = 0, r5_arm = 0;
  bit b_wr = 0;
  int b_len = 0, b_idx = 0;
  logic [ADDR_W-1:0] b_addr = '0;
  logic [CMD_W-1:0]  b_cmd = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor / scoreboard, sampled mid-cycle after inputs settle
  task automatic sample();
    bit offer;
    offer = b_wr ? wr_valid : !rd_full;
    if (r8_arm) chk(!init_rdy, "R8 wait state held", init_rdy, 0);
    if (r5_arm) chk(init_rdy, "R5 ready held until target", init_rdy, 1);
    r8_arm = (in_burst || pend_addr) && !turn && !init_rdy && !offer;
    r5_arm = in_burst && init_rdy && !tgt_rdy;
    if (rd_push) begin
      if (exp_rd.size() == 0) chk(0, "R7 unexpected push", rd_data, 0);
      else begin
        logic [DATA_W-1:0] e;
        e = exp_rd.pop_front();
        chk(rd_data == e, "R7 read word", rd_data, e);
      end
    end
    if (wr_pop && src_wr.size() != 0) void'(src_wr.pop_front());
    if (in_burst) begin
      if (turn) begin
        chk(!ad_oe, "R6 turnaround floats bus", ad_oe, 0);
        turn = 0;
      end else if (init_rdy && tgt_rdy) begin
        chk(bus_hold == ((b_len - b_idx) > 1), "R4 hold vs words left", bus_hold, (b_len - b_idx) > 1);
        if (b_len == 1) chk(!bus_hold && init_rdy, "R12 single word phase", bus_hold, 0);
        chk(cur_addr == ADDR_W'(b_addr + ADDR_W'(b_idx)), "R9 word address", cur_addr,
            ADDR_W'(b_addr + ADDR_W'(b_idx)));
        if (b_wr) begin
          logic [DATA_W-1:0] e;
          e = (exp_wr.size() != 0) ? exp_wr.pop_front() : '0;
          chk(ad_oe && ad_out == e, "R3 write word", ad_out, e);
        end else begin
          exp_rd.push_back(ad_in);
          rd_seq++;
        end
        b_idx++;
        if (b_idx == b_len) begin in_burst = 0; post_chk = 1; end
      end
    end else if (post_chk) begin
      chk(!bus_hold && !init_rdy && !ad_oe && !busy, "R10 bus released",
          {bus_hold, init_rdy, ad_oe, busy}, 0);
      post_chk = 0;
    end
    if (pend_addr) begin
      chk(bus_hold && ad_oe && !init_rdy && busy, "R2 address phase controls",
          {bus_hold, ad_oe, init_rdy, busy}, 4'b1101);
      chk(ad_out == DATA_W'(b_addr), "R2 address value", ad_out, b_addr);
      chk(cbe_out == b_cmd, "R2 command value", cbe_out, b_cmd);
      pend_addr = 0; in_burst = 1; turn = !b_wr;
    end
    if (start && !busy && start_len != '0 && !in_burst && !pend_addr) begin
      pend_addr = 1; b_wr = start_wr; b_len = int'(start_len); b_idx = 0;
      b_addr = start_addr; b_cmd = start_cmd;
    end
  endtask

  always @(negedge clk) begin
    cyc_n++;
    tgt_rdy  = stress ? ((cyc_n % 3) != 1) : 1'b1;
    wr_valid = (src_wr.size() != 0) && (!stress || (cyc_n % 4) != 2);
    wr_data  = (src_wr.size() != 0) ? src_wr[0] : '0;
    rd_full  = stress && ((cyc_n % 5) == 3);
    ad_in    = 32'hA500_0000 ^ rd_seq;
    #5;
    if (!rst) sample();
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
      finish_run();
    end
  end

  task automatic run(input bit wr, input logic [CMD_W-1:0] cmd, input logic [ADDR_W-1:0] addr,
                     input int len, input bit poke);
    while (busy || in_burst || pend_addr || post_chk) @(negedge clk);
    if (wr) for (int i = 0; i < len; i++) begin
      wseq = wseq + 32'h0101_0101;
      src_wr.push_back(wseq ^ 32'h3C00_0000);
      exp_wr.push_back(wseq ^ 32'h3C00_0000);
    end
    start = 1; start_wr = wr; start_cmd = cmd; start_addr = addr; start_len = LEN_W'(len);
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R11: a start while busy must not disturb the running burst
      repeat (3) @(negedge clk);
      start = 1; start_wr = !wr; start_addr = 16'h7777; start_len = 5; start_cmd = 4'hF;
      @(negedge clk);
      start = 0;
    end
    while (busy || in_burst || pend_addr || post_chk) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy && !bus_hold && !init_rdy && !ad_oe && !rd_push && !wr_pop, "R1 reset state",
        {busy, bus_hold, init_rdy, ad_oe, rd_push, wr_pop}, 0);
    rst = 0;
    @(negedge clk);
    chk(!busy && !bus_hold && !init_rdy && !ad_oe, "R1 after reset",
        {busy, bus_hold, init_rdy, ad_oe}, 0);

    run(1, 4'h7, 16'h0100, 1, 0);   // R12 write, single word
    run(0, 4'h6, 16'h0200, 1, 0);   // R12 read, single word
    run(1, 4'h7, 16'h0300, 4, 0);   // R3 clean write burst
    stress = 1;
    run(1, 4'h7, 16'h0400, 6, 0);   // R8 write with source gaps
    run(0, 4'h6, 16'h0500, 7, 0);   // R7 R8 read with sink full
    run(0, 4'hE, 16'hFFFE, 20, 0);  // R9 address wrap
    run(1, 4'h7, 16'h0600, 10, 1);  // R11 start while busy
    run(0, 4'h6, 16'h0700, 1, 0);   // R12 single read under stalls

    // R11: zero-length start is ignored
    start = 1; start_wr = 1; start_len = 0; start_addr = 16'h0900;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy && !bus_hold && !ad_oe, "R11 zero length ignored", {busy, bus_hold, ad_oe}, 0);
    end
    stress = 0;
    run(0, 4'h6, 16'h0A00, 3, 0);   // back to back
    run(1, 4'h7, 16'h0B00, 2, 0);
    repeat (4) @(negedge clk);
    chk(exp_wr.size() == 0 && src_wr.size() == 0, "R3 all write words moved", exp_wr.size(), 0);
    chk(exp_rd.size() == 0, "R7 all read words returned", exp_rd.size(), 0);
    finish_run();
  end
endmodule